// File: doc/BRIEF.md
# PCI Host Bridge Window Register File

This block is the configuration store of a PCI host bridge. It keeps the programmable state that a separate address translator needs: four window base registers, four window mask registers, four translated-base registers and one control register, each 64 bits wide. All thirteen values leave the block on dedicated output buses, so the translator always sees the current setting.

Software reaches the registers through a 64-bit slave port. A request carries a byte offset inside a 4 KB aperture, a size code, a write flag and write data. It completes when valid and ready are both high. Exactly one cycle later the block returns a registered response with read data and an error bit. Registers sit on 64-byte strides.

Several slots are placeholders for features the bridge lacks. Some read as zero and quietly drop writes. The rest, along with every undecoded slot, report an error.

Top module: `bcsr_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, every window base, window mask and translated-base register reads zero on its export bus. The control register reads 64'h0000_0021_0010_0000 (bit 20 set, bit 32 set, value 2 in the field starting at bit 36). rsp_valid is low.
- R2: The register index is the byte offset shifted right by 6. Offset bits 5:0 are ignored. Index map: 0–3 window base 0–3, 4–7 window mask 0–3, 8–11 translated base 0–3, 12 control, 15 error status, 16 error mask, 19 invalidate-all.
- R3: A request is accepted when req_valid and req_ready are both high. rsp_valid is high in exactly the cycle after each accepted request and low otherwise.
- R4: An accepted error-free write to index 0–12 stores req_wdata. The new value appears on the matching export bus in the cycle after acceptance.
- R5: The legal size is req_size = 3 (8 bytes). A request with any other size code responds with rsp_err = 1.
- R6: Offsets of 0xFFF or higher lie outside the aperture and respond with rsp_err = 1.
- R7: The error-status slot (index 15) reads zero without error. A write to it is accepted without error and changes no register.
- R8: The invalidate-all slot (index 19) reads zero without error. A write to it is accepted without error and changes no register.
- R9: The error-mask slot (index 16) reads zero without error. A write to it responds with rsp_err = 1.
- R10: Indices 13, 14, 17, 18, 20, 21 and every index from 22 up respond with rsp_err = 1 on both reads and writes.
- R11: An errored response carries rsp_rdata = 0. An errored write changes no register.
- R12: An error-free read of index 0–12 returns the value the register held before the accepting clock edge. A write response carries rsp_rdata = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (high outside reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the aperture |
| req_size | input | 2 | Log2 of access bytes; 3 is the only legal value |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_err | output | 1 | Access error flag |
| rsp_rdata | output | 64 | Read data (zero for writes and errors) |
| win_base_o | output | 4*64 | Window base registers, slot 0 in the low bits |
| win_mask_o | output | 4*64 | Window mask registers, slot 0 in the low bits |
| xlat_base_o | output | 4*64 | Translated-base registers, slot 0 in the low bits |
| ctl_o | output | 64 | Control register |

## Verification
The bench goes after the aperture edge at offset 0xFFF and the sub-word size codes. A design that checked these loosely would either return register data or corrupt a register through an illegal access.

It also exercises the asymmetric error-mask slot, which is readable but not writable. The two silent stubs come next: a wrong design there flags errors software does not expect, or lets the write land on a neighbouring register. Random offsets carry arbitrary low six bits, which catches a decoder that uses the wrong shift. Export buses are compared after every transaction, so a write that leaks into the wrong slot or survives an error shows up at once.

// File: rtl/bcsr_pkg.sv
package bcsr_pkg;
  localparam int NWIN    = 4;
  localparam int DW      = 64;
  localparam int SLOT_W  = $clog2(NWIN);
  localparam int IDX_MASK0 = NWIN;
  localparam int IDX_XLAT0 = 2 * NWIN;
  localparam int IDX_CTL   = 3 * NWIN;
  localparam int IDX_ESTAT = 15;
  localparam int IDX_EMASK = 16;
  localparam int IDX_TINV  = 19;
  localparam logic [DW-1:0] CTL_RST =
    (DW'(1) << 20) | (DW'(1) << 32) | (DW'(2) << 36);

  typedef enum logic [2:0] {
    K_BASE, K_MASK, K_XLAT, K_CTL, K_ESTAT, K_EMASK, K_TINV, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [SLOT_W-1:0] slot;
    logic              err;
  } dec_t;
endpackage

// File: rtl/bcsr_decode.sv
module bcsr_decode
  import bcsr_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int unsigned APERTURE  = 32'h0FFF,
  parameter int          STRIDE_LG = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  output dec_t              dec
);
  int unsigned idx;
  logic        in_ap;
  logic        size_ok;

  always_comb begin
    idx     = 32'(addr >> STRIDE_LG);
    in_ap   = 32'(addr) < APERTURE;
    size_ok = (size == 2'd3);
    dec.slot = '0;
    if (idx < 32'(IDX_MASK0)) begin
      dec.kind = K_BASE;
      dec.slot = SLOT_W'(idx);
    end else if (idx < 32'(IDX_XLAT0)) begin
      dec.kind = K_MASK;
      dec.slot = SLOT_W'(idx - 32'(IDX_MASK0));
    end else if (idx < 32'(IDX_CTL)) begin
      dec.kind = K_XLAT;
      dec.slot = SLOT_W'(idx - 32'(IDX_XLAT0));
    end else if (idx == 32'(IDX_CTL))   dec.kind = K_CTL;
    else if (idx == 32'(IDX_ESTAT))     dec.kind = K_ESTAT;
    else if (idx == 32'(IDX_EMASK))     dec.kind = K_EMASK;
    else if (idx == 32'(IDX_TINV))      dec.kind = K_TINV;
    else                                dec.kind = K_BAD;
    dec.err = !in_ap || !size_ok || (dec.kind == K_BAD) ||
              (dec.kind == K_EMASK && write);
  end
endmodule

// File: rtl/bcsr_bank.sv
module bcsr_bank
  import bcsr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  kind_e                     kind,
  input  logic [SLOT_W-1:0]         slot,
  input  logic [DW-1:0]             wdata,
  output logic [NWIN-1:0][DW-1:0]   base_o,
  output logic [NWIN-1:0][DW-1:0]   mask_o,
  output logic [NWIN-1:0][DW-1:0]   xlat_o,
  output logic [DW-1:0]             ctl_o,
  output logic [DW-1:0]             rdata
);
  for (genvar g = 0; g < NWIN; g++) begin : g_slot
    logic [DW-1:0] b_q, m_q, x_q;
    logic          hit;
    assign hit = we && (slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        b_q <= '0;
        m_q <= '0;
        x_q <= '0;
      end else if (hit) begin
        if (kind == K_BASE) b_q <= wdata;
        if (kind == K_MASK) m_q <= wdata;
        if (kind == K_XLAT) x_q <= wdata;
      end
    end
    assign base_o[g] = b_q;
    assign mask_o[g] = m_q;
    assign xlat_o[g] = x_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                       ctl_o <= CTL_RST;
    else if (we && kind == K_CTL)  ctl_o <= wdata;
  end

  always_comb begin
    case (kind)
      K_BASE:  rdata = base_o[slot];
      K_MASK:  rdata = mask_o[slot];
      K_XLAT:  rdata = xlat_o[slot];
      K_CTL:   rdata = ctl_o;
      default: rdata = '0;
    endcase
  end

  // R4: a control write lands on the export one cycle later
  a_r4_ctl_write: assert property (@(posedge clk) disable iff (rst)
    (we && kind == K_CTL) |=> (ctl_o == $past(wdata)));
  // R7/R8: the silent stubs never touch the control register
  a_r7_stub_keeps_ctl: assert property (@(posedge clk) disable iff (rst)
    (we && (kind == K_ESTAT || kind == K_TINV)) |=> $stable(ctl_o));
endmodule

// File: rtl/bcsr_top.sv
module bcsr_top
  import bcsr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int unsigned APERTURE = 32'h0FFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [DW-1:0]        rsp_rdata,
  output logic [NWIN*DW-1:0]   win_base_o,
  output logic [NWIN*DW-1:0]   win_mask_o,
  output logic [NWIN*DW-1:0]   xlat_base_o,
  output logic [DW-1:0]        ctl_o
);
  dec_t                    dec;
  logic                    fire;
  logic                    we;
  logic [DW-1:0]           rd;
  logic [NWIN-1:0][DW-1:0] base_w, mask_w, xlat_w;

  assign req_ready = !rst;
  assign fire      = req_valid && req_ready;
  assign we        = fire && req_write && !dec.err;

  bcsr_decode #(.ADDR_W(ADDR_W), .APERTURE(APERTURE), .STRIDE_LG(6)) u_dec (
    .addr(req_addr), .size(req_size), .write(req_write), .dec(dec)
  );

  bcsr_bank u_bank (
    .clk(clk), .rst(rst), .we(we), .kind(dec.kind), .slot(dec.slot),
    .wdata(req_wdata), .base_o(base_w), .mask_o(mask_w), .xlat_o(xlat_w),
    .ctl_o(ctl_o), .rdata(rd)
  );

  assign win_base_o  = base_w;
  assign win_mask_o  = mask_w;
  assign xlat_base_o = xlat_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire;
      rsp_err   <= fire && dec.err;
      rsp_rdata <= (fire && !req_write && !dec.err) ? rd : '0;
    end
  end

  // R3: exactly one response per accepted request
  a_r3_rsp_after_fire: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsp_valid);
  a_r3_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !rsp_valid);
  // R5: bad size code is an error
  a_r5_size_err: assert property (@(posedge clk) disable iff (rst)
    (fire && req_size != 2'd3) |=> rsp_err);
  // R6: outside the aperture is an error
  a_r6_aperture_err: assert property (@(posedge clk) disable iff (rst)
    (fire && 32'(req_addr) >= APERTURE) |=> rsp_err);
  // R11: errored responses carry no data
  a_r11_err_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));
  a_r11_err_write_stable: assert property (@(posedge clk) disable iff (rst)
    (fire && req_write && req_size != 2'd3) |=>
      ($stable(ctl_o) && $stable(win_base_o) && $stable(win_mask_o) &&
       $stable(xlat_base_o)));
  // R9: a write to the error-mask slot is an error
  a_r9_emask_write: assert property (@(posedge clk) disable iff (rst)
    (fire && req_write && req_size == 2'd3 && (req_addr >> 6) == ADDR_W'(16))
      |=> rsp_err);
endmodule

// File: tb/bcsr_top_test.sv
`timescale 1ns/1ps
module bcsr_top_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic        req_ready;
  logic        req_write = 0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = 2'd3;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [255:0] win_base_o, win_mask_o, xlat_base_o;
  logic [63:0] ctl_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [63:0] m_base [4];
  logic [63:0] m_mask [4];
  logic [63:0] m_xlat [4];
  logic [63:0] m_ctl;
  localparam logic [63:0] CTL_INIT = 64'h0000_0021_0010_0000;

  always #10 clk = ~clk;

  bcsr_top uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .win_base_o(win_base_o), .win_mask_o(win_mask_o),
    .xlat_base_o(xlat_base_o), .ctl_o(ctl_o)
  );

  task automatic chk(input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_exports(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(tag, win_base_o[i*64 +: 64], m_base[i]);
      chk(tag, win_mask_o[i*64 +: 64], m_mask[i]);
      chk(tag, xlat_base_o[i*64 +: 64], m_xlat[i]);
    end
    chk(tag, ctl_o, m_ctl);
  endtask

  function automatic string tag_of(input bit wr, input logic [15:0] a,
                                   input logic [1:0] sz);
    int idx = int'(a >> 6);
    if (a >= 16'h0FFF) return "R6";
    if (sz != 2'd3)    return "R5";
    if (idx <= 12)     return wr ? "R4" : "R12";
    if (idx == 15)     return "R7";
    if (idx == 16)     return "R9";
    if (idx == 19)     return "R8";
    return "R10";
  endfunction

  task automatic xact(input bit wr, input logic [15:0] a,
                      input logic [1:0] sz, input logic [63:0] d);
    int          idx = int'(a >> 6);
    bit          e_err;
    logic [63:0] e_rd = '0;
    string       tg = tag_of(wr, a, sz);
    e_err = (a >= 16'h0FFF) || (sz != 2'd3);
    if (!e_err) begin
      if (idx < 4)        e_rd = m_base[idx];
      else if (idx < 8)   e_rd = m_mask[idx-4];
      else if (idx < 12)  e_rd = m_xlat[idx-8];
      else if (idx == 12) e_rd = m_ctl;
      else if (idx == 15 || idx == 19) e_rd = '0;
      else if (idx == 16) e_err = wr;
      else                e_err = 1;
    end
    if (wr || e_err) e_rd = '0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk("R3 rsp_valid", {63'b0, rsp_valid}, 64'd1);
    chk({tg, " err"}, {63'b0, rsp_err}, {63'b0, e_err});
    chk({tg, (e_err ? " R11 rdata" : " rdata")}, rsp_rdata, e_rd);
    if (wr && !e_err) begin
      if (idx < 4)        m_base[idx]   = d;
      else if (idx < 8)   m_mask[idx-4] = d;
      else if (idx < 12)  m_xlat[idx-8] = d;
      else if (idx == 12) m_ctl = d;
    end
    chk_exports(e_err ? "R11 exports" : "R4 exports");
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_xlat[i] = '0;
    end
    m_ctl = CTL_INIT;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", {63'b0, rsp_valid}, 64'd0);
    chk_exports("R1 reset exports");
    rst = 0;
    @(negedge clk);
    chk("R1 ctl after reset", ctl_o, CTL_INIT);
    chk("R3 idle", {63'b0, rsp_valid}, 64'd0);

    // directed corner cases
    xact(0, 16'h0300, 2'd3, 0);                      // R12 control reset value
    xact(1, 16'h007A, 2'd3, 64'hDEAD_BEEF_0123_4567); // R2 low bits ignored
    xact(0, 16'h0040, 2'd3, 0);                      // R2 read back slot 1
    xact(1, 16'h0FFF, 2'd3, 64'h1);                  // R6 first offset outside
    xact(0, 16'h0FC0, 2'd3, 0);                      // R10 last slot in aperture
    xact(1, 16'h0000, 2'd2, 64'h55);                 // R5 32-bit write dropped
    xact(0, 16'h0000, 2'd0, 0);                      // R5 byte read
    xact(1, 16'h03C0, 2'd3, 64'hFFFF);               // R7 error status write
    xact(0, 16'h03C0, 2'd3, 0);                      // R7
    xact(1, 16'h04C0, 2'd3, 64'hABCD);               // R8 invalidate-all write
    xact(0, 16'h04C0, 2'd3, 0);                      // R8
    xact(0, 16'h0400, 2'd3, 0);                      // R9 readable
    xact(1, 16'h0400, 2'd3, 64'h77);                 // R9 write errors
    xact(0, 16'h0340, 2'd3, 0);                      // R10 index 13
    xact(1, 16'h0500, 2'd3, 64'h9);                  // R10 index 20
    xact(1, 16'h0300, 2'd3, 64'h0123_4567_89AB_CDEF); // R4 control
    xact(0, 16'h0300, 2'd3, 0);                      // R12
    @(negedge clk);
    chk("R3 no response when idle", {63'b0, rsp_valid}, 64'd0);

    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [1:0]  sz;
      a  = 16'(($urandom_range(0, 23) << 6) | $urandom_range(0, 63));
      if ($urandom_range(0, 15) == 0) a = 16'(32'h0FFF + $urandom_range(0, 300));
      sz = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 2)) : 2'd3;
      xact($urandom_range(0, 1) == 1, a, sz, {$urandom, $urandom});
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule